// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line of a small direct-mapped cache that shares a snooping bus with other caches. Each line holds one of four states (Invalid, Shared, Exclusive, Modified) and a tag. The block serves the local processor's read and write requests, issues bus transactions when a request cannot be finished locally, and watches transactions that other caches place on the bus.

When another cache tries to read or write a line that this cache holds Modified, the block does not pass the data across. It raises a wait signal so that the other requester backs off. It then writes the line back to memory and only after that releases the wait. A parameter chooses the write-miss policy. Either the line is fetched with ownership and kept Modified, or the write goes through to memory and the cache is left as it was.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ready` is 1, `bus_req_valid`, `snp_wait` and `cpu_done` are 0, snoops report no shared hit, and the first read of any address issues a bus read.
- R2: A read miss issues one bus read (`bus_req_cmd` 0) for the request address. The line becomes Exclusive if `bus_shared_in` is 0 in the cycle that `bus_done` is 1, and Shared otherwise.
- R3: A read hit, a write hit on Modified, and a write hit on Exclusive finish with no bus transaction, with `cpu_done` high in the cycle after the request is accepted. A write on Exclusive turns the line Modified.
- R4: A local write to a Shared line issues a read-for-ownership (`bus_req_cmd` 1) for that address, which invalidates the other copies, and leaves the line Modified.
- R5: A snooped read (`snp_cmd` 0) that hits a Modified line raises `snp_shared` and `snp_wait` in the snoop cycle. `snp_wait` stays high until the write-back (`bus_req_cmd` 2) of that address receives `bus_done`. The line is then Shared.
- R6: A snooped read-for-ownership (`snp_cmd` 1) or write-through (`snp_cmd` 3) that hits a Modified line raises `snp_wait`, writes the line back, and then leaves it Invalid.
- R7: A snooped read that hits Exclusive or Shared leaves the line Shared. A snooped read-for-ownership or write-through that hits Exclusive or Shared makes it Invalid. Neither raises `snp_wait` or issues a bus transaction, and both raise `snp_shared`.
- R8: A snoop takes priority over a local request presented in the same cycle. While `snp_wait` is high, `cpu_ready` is 0, and a request held through the wait is served after the write-back.
- R9: With WRITE_ALLOC = 1, a write miss issues one read-for-ownership for the address and leaves the line Modified.
- R10: With WRITE_ALLOC = 0, a write miss issues one write-through (`bus_req_cmd` 3) for the address. The address stays uncached and the line already resident at that index is unchanged.
- R11: A miss whose index holds a Modified line with another tag first writes back that victim's address, then fetches the new line. A clean victim is dropped without a write-back.
- R12: Once raised, `bus_req_valid` with its command and address stays constant until `bus_done`.
- R13: A snooped write-back (`snp_cmd` 2), or a snoop whose tag does not match the resident line, changes no state and raises neither `snp_shared` nor `snp_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the local request |
| cpu_ready | output | 1 | Local request accepted this cycle if valid |
| cpu_done | output | 1 | One-cycle pulse when a local request completes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 write-back, 3 write-through |
| bus_req_addr | output | ADDR_W | Line address of the bus transaction |
| bus_done | input | 1 | Current bus transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the fetched line (valid with bus_done) |
| snp_valid | input | 1 | Transaction from another cache is being snooped |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Snoop hits a valid copy here |
| snp_wait | output | 1 | Other requester must hold off until write-back ends |

## Verification
The hardest case to reach is a snoop that hits a Modified line in the same cycle as a local request to a different index. It tests both the snoop's priority and the hold-off of the local request across the whole write-back. The bench gets a line into Modified through a write miss with allocation, presents both requests in one cycle, keeps the local request asserted through the wait, and then checks the order of the write-back and the fetch in the bus log. Modified lines left by the silent Exclusive-to-Modified upgrade are also probed. No bus transaction reveals that upgrade, so a later snooped read must raise the wait to show the state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        BUS_RD  = 2'd0,
        BUS_RFO = 2'd1,
        BUS_WB  = 2'd2,
        BUS_WT  = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNP_WB,
        ST_EVICT,
        ST_FETCH,
        ST_WTHRU
    } ctl_st_t;

    typedef enum logic [2:0] {
        ACT_HIT,
        ACT_SILENT_M,
        ACT_FETCH,
        ACT_EVICT,
        ACT_WTHRU
    } local_act_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] a_idx,
    input  logic [INDEX_W-1:0] b_idx,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  mesi_t              wr_state,
    input  logic [TAG_W-1:0]   wr_tag,
    output mesi_t              a_state,
    output logic [TAG_W-1:0]   a_tag,
    output mesi_t              b_state,
    output logic [TAG_W-1:0]   b_tag
);
    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        mesi_t            st;
        logic [TAG_W-1:0] tag;
    } line_t;

    line_t line_vec [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && (wr_idx == INDEX_W'(i))) begin
                line_d.st  = wr_state;
                line_d.tag = wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '{st: MESI_I, tag: '0};
            end else begin
                line_q <= line_d;
            end
        end

        assign line_vec[i] = line_q;
    end

    assign a_state = line_vec[a_idx].st;
    assign a_tag   = line_vec[a_idx].tag;
    assign b_state = line_vec[b_idx].st;
    assign b_tag   = line_vec[b_idx].tag;

endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  mesi_t            line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             need_wb,
    output mesi_t            next_state
);
    logic tag_match;
    logic relevant;

    always_comb begin
        tag_match  = (line_tag == snp_tag) && (line_state != MESI_I);
        relevant   = snp_valid && (snp_cmd != BUS_WB);
        hit        = relevant && tag_match;
        need_wb    = hit && (line_state == MESI_M);
        next_state = (snp_cmd == BUS_RD) ? MESI_S : MESI_I;
    end

    // R7: a foreign ownership request never leaves a valid copy behind
    always_comb begin
        if (hit && (snp_cmd != BUS_RD)) begin
            a_r7_own_kills: assert (next_state == MESI_I);
        end
    end

endmodule

// File: rtl/mesi_local_eval.sv
module mesi_local_eval
    import mesi_pkg::*;
#(
    parameter int TAG_W       = 5,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    input  mesi_t            line_state,
    input  logic [TAG_W-1:0] line_tag,
    output local_act_t       act,
    output bus_cmd_t         fetch_cmd
);
    logic       line_hit;
    logic       victim_dirty;
    local_act_t wmiss_act;

    assign line_hit     = (line_state != MESI_I) && (line_tag == req_tag);
    assign victim_dirty = (line_state == MESI_M);

    if (WRITE_ALLOC) begin : g_alloc
        assign wmiss_act = victim_dirty ? ACT_EVICT : ACT_FETCH;
    end else begin : g_noalloc
        assign wmiss_act = ACT_WTHRU;
    end

    always_comb begin
        act       = ACT_HIT;
        fetch_cmd = BUS_RD;
        if (!req_write) begin
            if (!line_hit) begin
                act = victim_dirty ? ACT_EVICT : ACT_FETCH;
            end
        end else begin
            fetch_cmd = BUS_RFO;
            if (line_hit) begin
                unique case (line_state)
                    MESI_M:  act = ACT_HIT;
                    MESI_E:  act = ACT_SILENT_M;
                    default: act = ACT_FETCH;
                endcase
            end else begin
                act = wmiss_act;
            end
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int INDEX_W     = 3,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_wait
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    typedef struct packed {
        ctl_st_t           st;
        logic [ADDR_W-1:0] addr;
        bus_cmd_t          fcmd;
        mesi_t             snext;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [INDEX_W-1:0] snp_idx, cpu_idx, req_idx, b_idx, wr_idx;
    logic [TAG_W-1:0]   snp_tag, cpu_tag, req_tag, a_tag, b_tag, wr_tag;
    mesi_t              a_state, b_state, wr_state, sn_next;
    logic               wr_en, sn_hit, sn_wb, idle;
    local_act_t         act;
    bus_cmd_t           fcmd, snp_cmd_e, cmd_out;

    assign snp_idx   = snp_addr[INDEX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:INDEX_W];
    assign cpu_idx   = cpu_req_addr[INDEX_W-1:0];
    assign cpu_tag   = cpu_req_addr[ADDR_W-1:INDEX_W];
    assign req_idx   = ctl_q.addr[INDEX_W-1:0];
    assign req_tag   = ctl_q.addr[ADDR_W-1:INDEX_W];
    assign idle      = (ctl_q.st == ST_IDLE);
    assign b_idx     = idle ? cpu_idx : req_idx;
    assign snp_cmd_e = bus_cmd_t'(snp_cmd);

    mesi_line_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (snp_idx),
        .b_idx    (b_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_state (wr_state),
        .wr_tag   (wr_tag),
        .a_state  (a_state),
        .a_tag    (a_tag),
        .b_state  (b_state),
        .b_tag    (b_tag)
    );

    mesi_snoop_eval #(
        .TAG_W (TAG_W)
    ) u_snoop (
        .snp_valid  (snp_valid && idle),
        .snp_cmd    (snp_cmd_e),
        .snp_tag    (snp_tag),
        .line_state (a_state),
        .line_tag   (a_tag),
        .hit        (sn_hit),
        .need_wb    (sn_wb),
        .next_state (sn_next)
    );

    mesi_local_eval #(
        .TAG_W       (TAG_W),
        .WRITE_ALLOC (WRITE_ALLOC)
    ) u_local (
        .req_write  (cpu_req_write),
        .req_tag    (cpu_tag),
        .line_state (b_state),
        .line_tag   (b_tag),
        .act        (act),
        .fetch_cmd  (fcmd)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = b_idx;
        wr_state   = MESI_I;
        wr_tag     = b_tag;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (snp_valid) begin
                    if (sn_wb) begin
                        ctl_d.st    = ST_SNP_WB;
                        ctl_d.addr  = snp_addr;
                        ctl_d.snext = sn_next;
                    end else if (sn_hit) begin
                        wr_en    = 1'b1;
                        wr_idx   = snp_idx;
                        wr_state = sn_next;
                        wr_tag   = a_tag;
                    end
                end else if (cpu_req_valid) begin
                    ctl_d.addr = cpu_req_addr;
                    ctl_d.fcmd = fcmd;
                    unique case (act)
                        ACT_HIT: ctl_d.done = 1'b1;
                        ACT_SILENT_M: begin
                            wr_en      = 1'b1;
                            wr_state   = MESI_M;
                            ctl_d.done = 1'b1;
                        end
                        ACT_FETCH: ctl_d.st = ST_FETCH;
                        ACT_EVICT: ctl_d.st = ST_EVICT;
                        default:   ctl_d.st = ST_WTHRU;
                    endcase
                end
            end
            ST_SNP_WB: begin
                if (bus_done) begin
                    wr_en    = 1'b1;
                    wr_state = ctl_q.snext;
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_EVICT: begin
                if (bus_done) begin
                    wr_en    = 1'b1;
                    wr_state = MESI_I;
                    ctl_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_done) begin
                    wr_en      = 1'b1;
                    wr_tag     = req_tag;
                    wr_state   = (ctl_q.fcmd == BUS_RFO) ? MESI_M :
                                 (bus_shared_in ? MESI_S : MESI_E);
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: begin
                if (bus_done) begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, fcmd: BUS_RD, snext: MESI_I, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (ctl_q.st)
            ST_FETCH: cmd_out = ctl_q.fcmd;
            ST_WTHRU: cmd_out = BUS_WT;
            default:  cmd_out = BUS_WB;
        endcase
    end

    assign cpu_ready     = idle && !snp_valid;
    assign cpu_done      = ctl_q.done;
    assign bus_req_valid = !idle;
    assign bus_req_cmd   = cmd_out;
    assign bus_req_addr  = (ctl_q.st == ST_EVICT) ? {b_tag, req_idx} : ctl_q.addr;
    assign snp_shared    = sn_hit;
    assign snp_wait      = (ctl_q.st == ST_SNP_WB) || sn_wb;

    // R8: a pending owner write-back blocks local requests
    a_r8_wait_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wait |-> !cpu_ready);

    // R12: an outstanding bus request holds its command and address
    a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_done) |=>
            (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

    // R5: the hold-off only ends with a completed bus transaction
    a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snp_wait) |-> $past(bus_done));

    // R3: completion follows either an accepted request or a finished bus cycle
    a_r3_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> ($past(cpu_ready && cpu_req_valid) || $past(bus_done)));

    // R11: a victim write-back is followed directly by the fetch
    a_r11_evict_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && (ctl_q.st == ST_EVICT)) |=>
            (bus_req_valid && (bus_req_cmd != 2'd2)));

endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_bus_model #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              shared_cfg,
    output logic              done,
    output logic              shared_out
);
    int                count;
    int                lat;
    logic [1:0]        log_cmd  [64];
    logic [ADDR_W-1:0] log_addr [64];

    assign shared_out = shared_cfg;

    always @(negedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            count <= 0;
            lat   <= 0;
        end else if (done) begin
            done <= 1'b0;
            lat  <= 0;
        end else if (req_valid) begin
            if (lat == 2) begin
                done                 <= 1'b1;
                log_cmd[count % 64]  <= req_cmd;
                log_addr[count % 64] <= req_addr;
                count                <= count + 1;
            end else begin
                lat <= lat + 1;
            end
        end
    end
endmodule

module mesi_snoop_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       sel = 1'b0;
    logic       shr = 1'b0;
    logic       d_cpu_valid = 1'b0, d_cpu_write = 1'b0;
    logic [7:0] d_cpu_addr = '0;
    logic       d_snp_valid = 1'b0;
    logic [1:0] d_snp_cmd = '0;
    logic [7:0] d_snp_addr = '0;

    logic       rdy_a, done_a, bv_a, bd_a, bs_a, sh_a, wt_a;
    logic [1:0] bc_a;
    logic [7:0] ba_a;
    logic       rdy_b, done_b, bv_b, bd_b, bs_b, sh_b, wt_b;
    logic [1:0] bc_b;
    logic [7:0] ba_b;

    mesi_snoop_ctrl #(.ADDR_W(8), .INDEX_W(3), .WRITE_ALLOC(1'b1)) u_mesi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(d_cpu_valid && !sel), .cpu_req_write(d_cpu_write),
        .cpu_req_addr(d_cpu_addr), .cpu_ready(rdy_a), .cpu_done(done_a),
        .bus_req_valid(bv_a), .bus_req_cmd(bc_a), .bus_req_addr(ba_a),
        .bus_done(bd_a), .bus_shared_in(bs_a),
        .snp_valid(d_snp_valid && !sel), .snp_cmd(d_snp_cmd), .snp_addr(d_snp_addr),
        .snp_shared(sh_a), .snp_wait(wt_a));

    mesi_snoop_ctrl #(.ADDR_W(8), .INDEX_W(3), .WRITE_ALLOC(1'b0)) u_mesi_snoop_ctrl_na (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(d_cpu_valid && sel), .cpu_req_write(d_cpu_write),
        .cpu_req_addr(d_cpu_addr), .cpu_ready(rdy_b), .cpu_done(done_b),
        .bus_req_valid(bv_b), .bus_req_cmd(bc_b), .bus_req_addr(ba_b),
        .bus_done(bd_b), .bus_shared_in(bs_b),
        .snp_valid(d_snp_valid && sel), .snp_cmd(d_snp_cmd), .snp_addr(d_snp_addr),
        .snp_shared(sh_b), .snp_wait(wt_b));

    mesi_bus_model #(.ADDR_W(8)) u_mem_a (.clk(clk), .rst_n(rst_n), .req_valid(bv_a),
        .req_cmd(bc_a), .req_addr(ba_a), .shared_cfg(shr), .done(bd_a), .shared_out(bs_a));
    mesi_bus_model #(.ADDR_W(8)) u_mem_b (.clk(clk), .rst_n(rst_n), .req_valid(bv_b),
        .req_cmd(bc_b), .req_addr(ba_b), .shared_cfg(shr), .done(bd_b), .shared_out(bs_b));

    wire cpu_ready  = sel ? rdy_b  : rdy_a;
    wire cpu_done   = sel ? done_b : done_a;
    wire snp_shared = sel ? sh_b   : sh_a;
    wire snp_wait   = sel ? wt_b   : wt_a;
    wire bus_valid  = sel ? bv_b   : bv_a;

    int n_tests = 0;
    int n_fail  = 0;

    function automatic int txn();
        return sel ? u_mem_b.count : u_mem_a.count;
    endfunction

    function automatic logic [1:0] cmd_back(input int k);
        int i = txn() - 1 - k;
        return sel ? u_mem_b.log_cmd[i % 64] : u_mem_a.log_cmd[i % 64];
    endfunction

    function automatic logic [7:0] addr_back(input int k);
        int i = txn() - 1 - k;
        return sel ? u_mem_b.log_addr[i % 64] : u_mem_a.log_addr[i % 64];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic cpu_op(input logic wr, input logic [7:0] a, output int ntx);
        int c0;
        int guard;
        c0 = txn();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        d_cpu_valid = 1'b1;
        d_cpu_write = wr;
        d_cpu_addr  = a;
        @(negedge clk);
        d_cpu_valid = 1'b0;
        guard = 0;
        while (!cpu_done && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        #1;
        if (guard >= 60) check(1'b0, "cpu_done timeout", 0, 1);
        ntx = txn() - c0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                         output logic sh, output logic wt, output int ntx);
        int c0;
        int guard;
        c0 = txn();
        @(negedge clk);
        d_snp_valid = 1'b1;
        d_snp_cmd   = c;
        d_snp_addr  = a;
        #1;
        sh = snp_shared;
        wt = snp_wait;
        @(negedge clk);
        d_snp_valid = 1'b0;
        guard = 0;
        while (snp_wait && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        #1;
        if (guard >= 60) check(1'b0, "snp_wait timeout", 0, 1);
        ntx = txn() - c0;
    endtask

    task automatic t_reset();
        logic sh, wt;
        int n;
        check_eq("R1 ready", cpu_ready, 1);
        check_eq("R1 bus idle", bus_valid, 0);
        check_eq("R1 wait", snp_wait, 0);
        check_eq("R1 done", cpu_done, 0);
        snoop(2'd0, 8'h10, sh, wt, n);
        check_eq("R1 snoop shared", sh, 0);
        shr = 1'b0;
        cpu_op(1'b0, 8'h10, n);
        check_eq("R1 first read txns", n, 1);
        check_eq("R1 first read cmd", cmd_back(0), 0);
    endtask

    task automatic t_exclusive_path();
        logic sh, wt;
        int n;
        shr = 1'b0;
        cpu_op(1'b0, 8'h11, n);
        check_eq("R2 miss txns", n, 1);
        check_eq("R2 miss cmd", cmd_back(0), 0);
        check_eq("R2 miss addr", addr_back(0), 8'h11);
        cpu_op(1'b1, 8'h11, n);
        check_eq("R3 silent E->M", n, 0);
        snoop(2'd0, 8'h11, sh, wt, n);
        check_eq("R5 shared", sh, 1);
        check_eq("R5 wait", wt, 1);
        check_eq("R5 wb txns", n, 1);
        check_eq("R5 wb cmd", cmd_back(0), 2);
        check_eq("R5 wb addr", addr_back(0), 8'h11);
        cpu_op(1'b1, 8'h11, n);
        check_eq("R5 line now S (write needs bus)", n, 1);
        check_eq("R4 rfo cmd", cmd_back(0), 1);
        cpu_op(1'b0, 8'h11, n);
        check_eq("R3 read hit M", n, 0);
    endtask

    task automatic t_shared_path();
        int n;
        shr = 1'b1;
        cpu_op(1'b0, 8'h22, n);
        shr = 1'b0;
        check_eq("R2 shared fill txns", n, 1);
        cpu_op(1'b1, 8'h22, n);
        check_eq("R4 write S txns", n, 1);
        check_eq("R4 write S cmd", cmd_back(0), 1);
        check_eq("R4 write S addr", addr_back(0), 8'h22);
        cpu_op(1'b1, 8'h22, n);
        check_eq("R4 line M after upgrade", n, 0);
    endtask

    task automatic t_snoop_owner();
        logic sh, wt;
        int n;
        snoop(2'd1, 8'h22, sh, wt, n);
        check_eq("R6 rfo wait", wt, 1);
        check_eq("R6 rfo wb", n, 1);
        check_eq("R6 rfo wb cmd", cmd_back(0), 2);
        snoop(2'd0, 8'h22, sh, wt, n);
        check_eq("R6 invalid after rfo", sh, 0);
        cpu_op(1'b0, 8'h23, n);
        cpu_op(1'b1, 8'h23, n);
        check_eq("R3 silent upgrade", n, 0);
        snoop(2'd3, 8'h23, sh, wt, n);
        check_eq("R6 wt wait", wt, 1);
        check_eq("R6 wt wb addr", addr_back(0), 8'h23);
        snoop(2'd0, 8'h23, sh, wt, n);
        check_eq("R6 invalid after wt", sh, 0);
    endtask

    task automatic t_snoop_clean();
        logic sh, wt;
        int n;
        shr = 1'b0;
        cpu_op(1'b0, 8'h33, n);
        snoop(2'd0, 8'h33, sh, wt, n);
        check_eq("R7 rd on E shared", sh, 1);
        check_eq("R7 rd on E no wait", wt, 0);
        check_eq("R7 rd on E no txn", n, 0);
        cpu_op(1'b1, 8'h33, n);
        check_eq("R7 E became S", n, 1);
        cpu_op(1'b0, 8'h34, n);
        snoop(2'd1, 8'h34, sh, wt, n);
        check_eq("R7 rfo on E no wait", wt, 0);
        snoop(2'd0, 8'h34, sh, wt, n);
        check_eq("R7 rfo on E invalidates", sh, 0);
        shr = 1'b1;
        cpu_op(1'b0, 8'h35, n);
        shr = 1'b0;
        snoop(2'd3, 8'h35, sh, wt, n);
        check_eq("R7 wt on S shared", sh, 1);
        snoop(2'd0, 8'h35, sh, wt, n);
        check_eq("R7 wt on S invalidates", sh, 0);
    endtask

    task automatic t_write_alloc();
        logic sh, wt;
        int n;
        cpu_op(1'b1, 8'h44, n);
        check_eq("R9 alloc txns", n, 1);
        check_eq("R9 alloc cmd", cmd_back(0), 1);
        check_eq("R9 alloc addr", addr_back(0), 8'h44);
        snoop(2'd0, 8'h44, sh, wt, n);
        check_eq("R9 allocated line is M", wt, 1);
    endtask

    task automatic t_evict();
        logic sh, wt;
        int n;
        cpu_op(1'b1, 8'h45, n);
        cpu_op(1'b0, 8'h4D, n);
        check_eq("R11 dirty evict txns", n, 2);
        check_eq("R11 wb first cmd", cmd_back(1), 2);
        check_eq("R11 wb victim addr", addr_back(1), 8'h45);
        check_eq("R11 fetch cmd", cmd_back(0), 0);
        check_eq("R11 fetch addr", addr_back(0), 8'h4D);
        snoop(2'd0, 8'h45, sh, wt, n);
        check_eq("R11 victim gone", sh, 0);
        cpu_op(1'b0, 8'h55, n);
        check_eq("R11 clean victim no wb", n, 1);
    endtask

    task automatic t_priority();
        int n, c0, guard;
        logic held;
        cpu_op(1'b1, 8'h46, n);
        c0 = txn();
        @(negedge clk);
        d_snp_valid = 1'b1; d_snp_cmd = 2'd0; d_snp_addr = 8'h46;
        d_cpu_valid = 1'b1; d_cpu_write = 1'b0; d_cpu_addr = 8'h17;
        #1;
        check_eq("R8 snoop first ready", cpu_ready, 0);
        check_eq("R8 wait raised", snp_wait, 1);
        @(negedge clk);
        d_snp_valid = 1'b0;
        #1;
        held = 1'b1;
        guard = 0;
        while (snp_wait && guard < 60) begin
            if (cpu_ready) held = 1'b0;
            @(negedge clk);
            #1;
            guard++;
        end
        check_eq("R8 ready low during wait", held, 1);
        while (!cpu_ready && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        d_cpu_valid = 1'b0;
        while (!cpu_done && guard < 90) begin
            @(negedge clk);
            guard++;
        end
        #1;
        check_eq("R8 txns", txn() - c0, 2);
        check_eq("R8 wb before fetch", cmd_back(1), 2);
        check_eq("R8 held request fetched", addr_back(0), 8'h17);
    endtask

    task automatic t_ignored();
        logic sh, wt;
        int n;
        cpu_op(1'b1, 8'h17, n);
        check_eq("R3 silent upgrade 0x17", n, 0);
        snoop(2'd1, 8'h1F, sh, wt, n);
        check_eq("R13 tag miss shared", sh, 0);
        check_eq("R13 tag miss wait", wt, 0);
        snoop(2'd2, 8'h17, sh, wt, n);
        check_eq("R13 wb snoop shared", sh, 0);
        check_eq("R13 wb snoop txns", n, 0);
        cpu_op(1'b0, 8'h17, n);
        check_eq("R13 line kept", n, 0);
        snoop(2'd0, 8'h17, sh, wt, n);
        check_eq("R13 line still M", wt, 1);
    endtask

    task automatic t_no_alloc();
        logic sh, wt;
        int n;
        sel = 1'b1;
        shr = 1'b0;
        cpu_op(1'b0, 8'h52, n);
        check_eq("R10 setup read", n, 1);
        cpu_op(1'b1, 8'h5A, n);
        check_eq("R10 wt txns", n, 1);
        check_eq("R10 wt cmd", cmd_back(0), 3);
        check_eq("R10 wt addr", addr_back(0), 8'h5A);
        cpu_op(1'b0, 8'h52, n);
        check_eq("R10 resident unchanged", n, 0);
        snoop(2'd0, 8'h5A, sh, wt, n);
        check_eq("R10 not cached", sh, 0);
        cpu_op(1'b1, 8'h61, n);
        check_eq("R10 empty-index wt", cmd_back(0), 3);
        cpu_op(1'b0, 8'h61, n);
        check_eq("R10 read after wt misses", n, 1);
        sel = 1'b0;
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_exclusive_path();
        t_shared_path();
        t_snoop_owner();
        t_snoop_clean();
        t_write_alloc();
        t_evict();
        t_priority();
        t_ignored();
        t_no_alloc();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule